// File: doc/BRIEF.md
# Segment Register Load and Translation Unit

This block is the segment stage of an address-generation path. It holds a small file of segment registers. Each one has a 16-bit visible selector and a hidden cache that records a base, an effective limit and two access-right bits. Software-visible loads rewrite the selector and refill the hidden cache together. Translation requests are served from the hidden cache only, so what a request sees depends on the last load and not on the current mode.

The way a load fills the cache depends on `prot_mode`, sampled when the load is accepted. In real mode the value goes straight into the selector. The cache becomes a 64 KiB read/write data segment based at value×16, and the load completes in a single cycle. In protected mode the selector is split into a table index, a table-select bit and a requested-privilege field. The unit issues a read of one 64-bit descriptor on the table port and waits for the acknowledge. It then decodes the descriptor, applies the rules for the target register, and either fills the cache or reports a fault while leaving the register untouched.

The translate port takes a register number, a 32-bit offset and a write flag. One cycle later it returns the linear address and a fault flag computed from the cached limit and rights.

Top module: `segment_unit`

## Requirements
- R1: After reset every selector reads 0 and every cache holds base 0, limit 0x0000FFFF, readable/writable data rights.
- R2: With `prot_mode`=0, an accepted load of any 16-bit value V into any register sets the selector to V, the base to V×16, the limit to 0xFFFF and read/write data rights. `ld_done` is high in the next cycle with `ld_fault_code`=0.
- R3: With `prot_mode`=1, an accepted load raises `tbl_rd_req` from the next cycle. The address is (selector bit 2 ? `ltab_base` : `gtab_base`) + selector[15:3]×8, and both request and address are held steady until `tbl_rd_ack`.
- R4: The descriptor is decoded as follows. Base = {bits 63:56, 39:32, 31:16}. The raw limit is {bits 51:48, 15:0}. When G (bit 55) is 1 the limit is raw×4096+0xFFF; otherwise it is the raw value.
- R5: A load is refused with `ld_fault_code`=1 (general protection) in any of these cases: bit 44 (S) is 0; register 0 (code) gets a descriptor with bit 43 (executable) clear; register 1 (stack) gets an executable or non-writable (bit 41 clear) descriptor; register 2 or 3 gets an executable descriptor with bit 41 (readable) clear.
- R6: A descriptor that passes R5 but has bit 47 (present) clear is refused with `ld_fault_code`=2 (not present). R5 faults take priority.
- R7: A refused load leaves that register's selector and cache unchanged. `ld_done` is high in the cycle after `tbl_rd_ack`, with the fault code; a non-zero code appears only together with `ld_done`.
- R8: A translate request returns, in the next cycle, `xl_rsp_valid`=1 and `xl_addr` = cached base + offset modulo 2^32.
- R9: An offset greater than the cached limit sets `xl_fault`.
- R10: A write to an executable segment, a write to a non-writable data segment, or a read of an executable non-readable segment sets `xl_fault`.
- R11: Changing `prot_mode` alone leaves every selector and cache unchanged; translations keep using the contents from the last load.
- R12: While `ld_busy` is high, `ld_valid` is ignored and no other register is altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode | input | 1 | 1 = protected loads, 0 = real-mode loads |
| gtab_base | input | 32 | Base address of the global descriptor table |
| ltab_base | input | 32 | Base address of the local descriptor table |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 2 | Target register (0 code, 1 stack, 2/3 data) |
| ld_sel | input | 16 | Value or selector to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_fault_code | output | 2 | 0 none, 1 general protection, 2 not present |
| tbl_rd_req | output | 1 | Descriptor read request |
| tbl_rd_addr | output | 32 | Descriptor read address |
| tbl_rd_ack | input | 1 | Descriptor data valid |
| tbl_rd_data | input | 64 | Descriptor returned by the table |
| xl_valid | input | 1 | Translate request |
| xl_seg | input | 2 | Register used for translation |
| xl_off | input | 32 | Effective offset |
| xl_write | input | 1 | 1 = write access, 0 = read |
| xl_rsp_valid | output | 1 | Translate result valid |
| xl_addr | output | 32 | Linear address |
| xl_fault | output | 1 | Limit or rights violation |
| sel_all | output | 64 | All visible selectors, register i at bits 16i+15:16i |

## Verification
The assertions assume that the table port answers each request with exactly one `tbl_rd_ack` while `tbl_rd_req` is high. They also assume that `tbl_rd_ack` stays low when no request is outstanding. The stimulus respects this because the table responder acknowledges only after it has seen the request and has checked the address. It stretches every fetch by one idle cycle so that the hold rule is exercised. `ld_valid` is pulsed into a busy fetch on purpose, and translate requests are issued only while no load is in flight.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int DESC_W   = 64;
    localparam int CODE_IDX  = 0;
    localparam int STACK_IDX = 1;
    localparam logic [ADDR_W-1:0] REAL_LIMIT = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              exec;
        logic              rw;
    } seg_cache_t;

    function automatic logic [ADDR_W-1:0] eff_limit(input logic [19:0] raw, input logic gran);
        return gran ? {raw, 12'hFFF} : {12'h000, raw};
    endfunction

    function automatic seg_cache_t real_cache(input logic [SEL_W-1:0] v);
        seg_cache_t c;
        c.base  = {12'h000, v, 4'h0};
        c.limit = REAL_LIMIT;
        c.exec  = 1'b0;
        c.rw    = 1'b1;
        return c;
    endfunction

    // sel_hi is selector bits 15:2 (index and table bit)
    function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] gbase,
                                                    input logic [ADDR_W-1:0] lbase,
                                                    input logic [13:0]       sel_hi);
        logic [ADDR_W-1:0] tb;
        tb = sel_hi[0] ? lbase : gbase;
        return tb + {16'h0000, sel_hi[13:1], 3'b000};
    endfunction

endpackage

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_pkg::*;
#(
    parameter int SEG_W = 2
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [DESC_W-1:0] desc,
    output seg_cache_t        cache,
    output fault_e            code
);
    logic is_sys, is_exec, is_rw, present, gran;
    logic is_code_reg, is_stack_reg, gp;
    logic unused_bits;

    assign is_sys  = ~desc[44];
    assign is_exec = desc[43];
    assign is_rw   = desc[41];
    assign present = desc[47];
    assign gran    = desc[55];
    assign unused_bits = ^{desc[54:52], desc[46:45], desc[42], desc[40]};

    assign is_code_reg  = (seg == SEG_W'(CODE_IDX));
    assign is_stack_reg = (seg == SEG_W'(STACK_IDX));

    always_comb begin
        cache.base  = {desc[63:56], desc[39:32], desc[31:16]};
        cache.limit = eff_limit({desc[51:48], desc[15:0]}, gran);
        cache.exec  = is_exec;
        cache.rw    = is_rw;

        gp = is_sys
           | (is_code_reg  & ~is_exec)
           | (is_stack_reg & (is_exec | ~is_rw))
           | (~is_code_reg & ~is_stack_reg & is_exec & ~is_rw);

        if (gp)            code = FLT_GP;
        else if (!present) code = FLT_NP;
        else               code = FLT_NONE;
    end
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
    import seg_pkg::*;
#(
    parameter int SEG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_mode,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic              tbl_rd_ack,
    input  seg_cache_t        chk_cache,
    input  fault_e            chk_code,
    output logic [SEG_W-1:0]  pend_seg,
    output logic              tbl_rd_req,
    output logic [ADDR_W-1:0] tbl_rd_addr,
    output logic              ld_busy,
    output logic              ld_done,
    output fault_e            ld_fault,
    output logic              wr_en,
    output logic [SEG_W-1:0]  wr_idx,
    output logic [SEL_W-1:0]  wr_sel,
    output seg_cache_t        wr_cache
);
    typedef enum logic {ST_IDLE, ST_FETCH} ld_state_e;

    ld_state_e         state_q;
    logic [SEG_W-1:0]  pend_seg_q;
    logic [SEL_W-1:0]  pend_sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign accept      = (state_q == ST_IDLE) && ld_valid;
    assign ld_busy     = (state_q == ST_FETCH);
    assign tbl_rd_req  = ld_busy;
    assign tbl_rd_addr = addr_q;
    assign pend_seg    = pend_seg_q;

    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = pend_seg_q;
        wr_sel   = pend_sel_q;
        wr_cache = chk_cache;
        if (state_q == ST_IDLE) begin
            wr_en    = accept && !prot_mode;
            wr_idx   = ld_seg;
            wr_sel   = ld_sel;
            wr_cache = real_cache(ld_sel);
        end else begin
            wr_en = tbl_rd_ack && (chk_code == FLT_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_seg_q <= '0;
            pend_sel_q <= '0;
            addr_q     <= '0;
            ld_done    <= 1'b0;
            ld_fault   <= FLT_NONE;
        end else begin
            ld_done  <= 1'b0;
            ld_fault <= FLT_NONE;
            case (state_q)
                ST_IDLE: if (ld_valid) begin
                    if (prot_mode) begin
                        state_q    <= ST_FETCH;
                        pend_seg_q <= ld_seg;
                        pend_sel_q <= ld_sel;
                        addr_q     <= desc_addr(gtab_base, ltab_base, ld_sel[15:2]);
                    end else begin
                        ld_done <= 1'b1;
                    end
                end
                ST_FETCH: if (tbl_rd_ack) begin
                    state_q  <= ST_IDLE;
                    ld_done  <= 1'b1;
                    ld_fault <= chk_code;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_req && !tbl_rd_ack) |=> (tbl_rd_req && $stable(tbl_rd_addr)));

    p_real_done_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld_busy && ld_valid && !prot_mode) |=> (ld_done && ld_fault == FLT_NONE));

    p_fault_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_fault != FLT_NONE) |-> ld_done);

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (ld_busy && ld_valid && !tbl_rd_ack) |=> (!ld_done && $stable(pend_seg_q)));
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int SEG_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEG_W-1:0]         wr_idx,
    input  logic [SEL_W-1:0]         wr_sel,
    input  seg_cache_t               wr_cache,
    input  logic [SEG_W-1:0]         rd_idx,
    output seg_cache_t               rd_cache,
    output logic [NUM_SEG*SEL_W-1:0] sel_flat
);
    seg_cache_t       cache_q [NUM_SEG];
    logic [SEL_W-1:0] sel_q   [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[i]   <= '0;
                cache_q[i] <= real_cache('0);
            end else if (wr_en && wr_idx == SEG_W'(i)) begin
                sel_q[i]   <= wr_sel;
                cache_q[i] <= wr_cache;
            end
        end
        assign sel_flat[i*SEL_W +: SEL_W] = sel_q[i];
    end

    assign rd_cache = cache_q[rd_idx];

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_flat));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xl_valid,
    input  logic [ADDR_W-1:0] xl_off,
    input  logic              xl_write,
    input  seg_cache_t        seg_c,
    output logic              xl_rsp_valid,
    output logic [ADDR_W-1:0] xl_addr,
    output logic              xl_fault
);
    logic over_limit, bad_rights;

    assign over_limit = xl_off > seg_c.limit;
    assign bad_rights = xl_write ? (seg_c.exec | ~seg_c.rw)
                                 : (seg_c.exec & ~seg_c.rw);

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_rsp_valid <= 1'b0;
            xl_addr      <= '0;
            xl_fault     <= 1'b0;
        end else begin
            xl_rsp_valid <= xl_valid;
            if (xl_valid) begin
                xl_addr  <= seg_c.base + xl_off;
                xl_fault <= over_limit | bad_rights;
            end
        end
    end

    p_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        xl_valid |=> xl_rsp_valid);

    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !xl_valid |=> !xl_rsp_valid);
endmodule

// File: rtl/segment_unit.sv
module segment_unit
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prot_mode,
    input  logic [31:0]              gtab_base,
    input  logic [31:0]              ltab_base,
    input  logic                     ld_valid,
    input  logic [SEG_W-1:0]         ld_seg,
    input  logic [15:0]              ld_sel,
    output logic                     ld_busy,
    output logic                     ld_done,
    output logic [1:0]               ld_fault_code,
    output logic                     tbl_rd_req,
    output logic [31:0]              tbl_rd_addr,
    input  logic                     tbl_rd_ack,
    input  logic [63:0]              tbl_rd_data,
    input  logic                     xl_valid,
    input  logic [SEG_W-1:0]         xl_seg,
    input  logic [31:0]              xl_off,
    input  logic                     xl_write,
    output logic                     xl_rsp_valid,
    output logic [31:0]              xl_addr,
    output logic                     xl_fault,
    output logic [NUM_SEG*16-1:0]    sel_all
);
    seg_cache_t       chk_cache, wr_cache, rd_cache;
    fault_e           chk_code, ld_fault;
    logic [SEG_W-1:0] pend_seg, wr_idx;
    logic [SEL_W-1:0] wr_sel;
    logic             wr_en;

    assign ld_fault_code = ld_fault;

    seg_desc_check #(.SEG_W(SEG_W)) u_check (
        .seg   (pend_seg),
        .desc  (tbl_rd_data),
        .cache (chk_cache),
        .code  (chk_code)
    );

    seg_load_fsm #(.SEG_W(SEG_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .prot_mode  (prot_mode),
        .gtab_base  (gtab_base),
        .ltab_base  (ltab_base),
        .ld_valid   (ld_valid),
        .ld_seg     (ld_seg),
        .ld_sel     (ld_sel),
        .tbl_rd_ack (tbl_rd_ack),
        .chk_cache  (chk_cache),
        .chk_code   (chk_code),
        .pend_seg   (pend_seg),
        .tbl_rd_req (tbl_rd_req),
        .tbl_rd_addr(tbl_rd_addr),
        .ld_busy    (ld_busy),
        .ld_done    (ld_done),
        .ld_fault   (ld_fault),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_sel     (wr_sel),
        .wr_cache   (wr_cache)
    );

    seg_cache_bank #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_sel   (wr_sel),
        .wr_cache (wr_cache),
        .rd_idx   (xl_seg),
        .rd_cache (rd_cache),
        .sel_flat (sel_all)
    );

    seg_addr_gen u_xlate (
        .clk         (clk),
        .rst         (rst),
        .xl_valid    (xl_valid),
        .xl_off      (xl_off),
        .xl_write    (xl_write),
        .seg_c       (rd_cache),
        .xl_rsp_valid(xl_rsp_valid),
        .xl_addr     (xl_addr),
        .xl_fault    (xl_fault)
    );
endmodule

// File: tb/segment_unit_tb.sv
module segment_unit_tb;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        prot_mode;
    logic [31:0] gtab_base, ltab_base;
    logic        ld_valid;
    logic [1:0]  ld_seg;
    logic [15:0] ld_sel;
    logic        ld_busy, ld_done;
    logic [1:0]  ld_fault_code;
    logic        tbl_rd_req;
    logic [31:0] tbl_rd_addr;
    logic        tbl_rd_ack;
    logic [63:0] tbl_rd_data;
    logic        xl_valid;
    logic [1:0]  xl_seg;
    logic [31:0] xl_off;
    logic        xl_write;
    logic        xl_rsp_valid;
    logic [31:0] xl_addr;
    logic        xl_fault;
    logic [63:0] sel_all;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_base [NS];
    logic [31:0] m_lim  [NS];
    logic        m_ex   [NS];
    logic        m_rw   [NS];
    logic [15:0] m_sel  [NS];

    always #10 clk = ~clk;

    segment_unit u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_sels();
        logic [63:0] v;
        for (int i = 0; i < NS; i++) v[i*16 +: 16] = m_sel[i];
        return v;
    endfunction

    function automatic bit exp_xl_fault(input int s, input logic [31:0] off, input bit wr);
        bit rights;
        rights = wr ? (m_ex[s] || !m_rw[s]) : (m_ex[s] && !m_rw[s]);
        return (off > m_lim[s]) || rights;
    endfunction

    task automatic translate(input int s, input logic [31:0] off, input bit wr, input string req);
        logic [31:0] ea;
        bit ef;
        @(negedge clk);
        xl_valid = 1'b1; xl_seg = 2'(s); xl_off = off; xl_write = wr;
        @(negedge clk);
        xl_valid = 1'b0;
        ea = m_base[s] + off;
        ef = exp_xl_fault(s, off, wr);
        chk(xl_rsp_valid == 1'b1, {req, " R8 rsp_valid"}, 64'(xl_rsp_valid), 64'd1);
        chk(xl_addr == ea, {req, " R8 addr"}, 64'(xl_addr), 64'(ea));
        chk(xl_fault == ef, {req, " R9/R10 fault"}, 64'(xl_fault), 64'(ef));
    endtask

    task automatic real_load(input int s, input logic [15:0] v);
        @(negedge clk);
        prot_mode = 1'b0; ld_valid = 1'b1; ld_seg = 2'(s); ld_sel = v;
        @(negedge clk);
        ld_valid = 1'b0;
        m_sel[s] = v; m_base[s] = {12'h0, v, 4'h0}; m_lim[s] = 32'hFFFF;
        m_ex[s] = 1'b0; m_rw[s] = 1'b1;
        chk(ld_done == 1'b1 && ld_fault_code == 2'd0, "R2 real done", {62'h0, ld_fault_code}, 64'd0);
        chk(sel_all == exp_sels(), "R2 real selector", sel_all, exp_sels());
    endtask

    task automatic prot_load(input int s, input logic [15:0] sel, input logic [63:0] d);
        logic [31:0] ea, lim;
        logic [19:0] raw;
        bit gp, np;
        logic [1:0] ecode;
        int other;
        other = (s + 1) % NS;
        ea = (sel[2] ? ltab_base : gtab_base) + {16'h0, sel[15:3], 3'b000};
        @(negedge clk);
        prot_mode = 1'b1; ld_valid = 1'b1; ld_seg = 2'(s); ld_sel = sel;
        @(negedge clk);
        chk(tbl_rd_req == 1'b1 && ld_busy == 1'b1, "R3 req raised", 64'(tbl_rd_req), 64'd1);
        chk(tbl_rd_addr == ea, "R3 fetch addr", 64'(tbl_rd_addr), 64'(ea));
        // stray load while busy: must be ignored (R12)
        ld_seg = 2'(other); ld_sel = 16'hBEEF; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(tbl_rd_req == 1'b1 && tbl_rd_addr == ea, "R3 req held", 64'(tbl_rd_addr), 64'(ea));
        tbl_rd_ack = 1'b1; tbl_rd_data = d;
        @(negedge clk);
        tbl_rd_ack = 1'b0;
        gp = !d[44] || (s == 0 && !d[43]) || (s == 1 && (d[43] || !d[41]))
             || (s >= 2 && d[43] && !d[41]);
        np = !gp && !d[47];
        ecode = gp ? 2'd1 : (np ? 2'd2 : 2'd0);
        chk(ld_done == 1'b1, "R7 done after ack", 64'(ld_done), 64'd1);
        chk(ld_fault_code == ecode, gp ? "R5 gp code" : (np ? "R6 np code" : "R5 accept code"),
            64'(ld_fault_code), 64'(ecode));
        if (ecode == 2'd0) begin
            raw = {d[51:48], d[15:0]};
            lim = d[55] ? ({12'h0, raw} * 32'd4096 + 32'hFFF) : {12'h0, raw};
            m_sel[s] = sel; m_base[s] = {d[63:56], d[39:32], d[31:16]};
            m_lim[s] = lim; m_ex[s] = d[43]; m_rw[s] = d[41];
        end
        chk(sel_all == exp_sels(), "R7/R12 selectors", sel_all, exp_sels());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12 actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; prot_mode = 1'b0; gtab_base = 32'h0010_0000; ltab_base = 32'h0200_0008;
        ld_valid = 1'b0; ld_seg = '0; ld_sel = '0; tbl_rd_ack = 1'b0; tbl_rd_data = '0;
        xl_valid = 1'b0; xl_seg = '0; xl_off = '0; xl_write = 1'b0;
        for (int i = 0; i < NS; i++) begin
            m_sel[i] = 16'h0; m_base[i] = 32'h0; m_lim[i] = 32'hFFFF; m_ex[i] = 1'b0; m_rw[i] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(sel_all == 64'h0, "R1 selectors", sel_all, 64'h0);
        chk(ld_busy == 1'b0 && ld_done == 1'b0, "R1 idle", 64'(ld_busy), 64'd0);
        for (int i = 0; i < NS; i++) begin
            translate(i, 32'hFFFF, 1'b1, "R1 limit");
            translate(i, 32'h1_0000, 1'b0, "R1 beyond");
        end
        // R2 real-mode loads, several values on every register
        for (int i = 0; i < NS; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] v;
                v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(16'h1234 * (k + i) + i);
                real_load(i, v);
                translate(i, 32'h0, 1'b1, "R2 base");
                translate(i, 32'hFFFF, 1'b0, "R2 limit");
                translate(i, 32'h1_0000, 1'b0, "R2 over");
            end
        end
        // R11: mode switch alone keeps real-mode contents
        @(negedge clk); prot_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(sel_all == exp_sels(), "R11 selectors after switch", sel_all, exp_sels());
        for (int i = 0; i < NS; i++) translate(i, 32'h0000_8000, 1'b1, "R11 cache kept");
        // R3-R7, R12: sweep type nibble, S and P over every register
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < 32; t++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [63:0] d;
                    logic [31:0] b;
                    logic [19:0] raw;
                    logic [15:0] sel;
                    logic g;
                    b   = 32'h1000_0000 * s + 32'h0001_0100 * t + 32'h40 * p + 32'h0F00_0000;
                    raw = {4'(t), 16'h0123 + 16'(p)};
                    g   = t[0] ^ p[0];
                    sel = {13'(t + s * 32 + p * 8 + 1), t[1], 2'(s)};
                    d = {b[31:24], g, 3'b100, raw[19:16], 1'(p), 2'b00, 5'(t), b[23:16], b[15:0], raw[15:0]};
                    prot_load(s, sel, d);
                    translate(s, 32'h0, 1'b0, "R4 base read");
                    translate(s, m_lim[s], 1'b0, "R9 at limit");
                    if (m_lim[s] != 32'hFFFF_FFFF)
                        translate(s, m_lim[s] + 32'd1, 1'b0, "R9 past limit");
                    translate(s, 32'h10, 1'b1, "R10 write");
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule